// File: doc/BRIEF.md
# First-Fault Predicated Vector Word Loader

This block loads a vector of 64-bit elements from consecutive 32-bit words in memory, one element position per step, under a per-element predicate. A start pulse supplies a 64-bit base, a 64-bit element index, the predicate and the current first-fault mask. The first word address is the base plus four times the index. Each loaded word is sign-extended into its element. Inactive positions are written as zero and never touch memory.

Faults follow first-fault rules. A fault on the first active element is a real trap. The block raises a trap flag and commits nothing. A fault on any later active element is suppressed. The fault mask bit of that element and every bit above it are cleared, and no further memory requests are made. The caller reads the partial vector and the shrunken mask and retries from the first cleared position.

Elements whose mask bit ends up zero are written as zero, so every outcome is deterministic. When the base comes from the stack pointer, its alignment is checked before any access.

Top module: `ffl_vload_seq`

## Requirements
- R1: The request for element e uses address base + 4*index + 4*e (modulo 2^64). The address advances by 4 for every element position, whether the element is active or not.
- R2: The loaded word of an active element whose input mask bit is 1 is sign-extended into bits [64e+63:64e] of `vec_o`. Bit 31 of the word fills the upper 32 bits.
- R3: An element with `pred_i[e]`=0 issues no memory request and is written as zero. Its mask bit is passed through unchanged, unless an earlier suppressed fault cleared it.
- R4: A fault on the first active element sets `trap_o` and `done_o` in the same cycle. `vec_o` and `ffr_o` keep their previous values.
- R5: A fault on a later active element raises no trap. It clears `ffr_o[e]` and every higher mask bit, and all of those elements are written as zero.
- R6: After a suppressed fault, no further memory request is issued for the rest of the vector.
- R7: An active element whose input mask bit is 0 is still read. Its result is zero, and its mask bit stays 0.
- R8: When `base_is_sp_i`=1, at least one element is active and `base_i[3:0]`!=0, the block raises `trap_o` and `align_trap_o` with `done_o`. It makes no memory request and commits nothing. With no active element, no alignment trap is raised.
- R9: `done_o` is a single-cycle pulse. The new `vec_o` and `ffr_o` are visible in the same cycle as `done_o`.
- R10: While `mem_req_valid_o`=1 and `mem_req_ready_i`=0, the request stays valid and its address is stable. Only one request is outstanding at a time.
- R11: After reset, `vec_o`=0, `ffr_o`=0, and `done_o`, `trap_o`, `align_trap_o` and `mem_req_valid_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| base_i | input | 64 | Base byte address |
| index_i | input | 64 | Element index, scaled by 4 |
| base_is_sp_i | input | 1 | Base comes from the stack pointer, so alignment is checked |
| pred_i | input | N | Per-element predicate |
| ffr_i | input | N | Incoming first-fault mask |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | 64 | Read byte address |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_data_i | input | 32 | Read word |
| mem_rsp_fault_i | input | 1 | Read faulted |
| vec_o | output | VL_BITS | Committed destination vector, element e at [64e+63:64e] |
| ffr_o | output | N | Committed first-fault mask |
| done_o | output | 1 | Completion pulse |
| trap_o | output | 1 | Trap, valid with done_o |
| align_trap_o | output | 1 | The trap came from the alignment check |

## Verification
The bench targets these cases:
- A fault on the first active element that sits behind inactive positions. A design that treated element 0 as "first" would suppress the fault there instead of trapping.
- A suppressed fault at the last position, and faults followed by inactive elements. A design with a non-sticky clear would leave higher mask bits set or issue extra requests.
- Mask bits that are already zero on input. A design that skipped those reads would lose later faults. A design that kept their data would return non-zero elements.
- Misaligned stack-pointer bases with and without active elements. Indices that wrap the 64-bit address space. Words with bit 31 set, which catch a zero-extension error.

// File: rtl/ffl_pkg.sv
package ffl_pkg;
  localparam int unsigned ELEM_W = 64;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_CHK, ST_STEP, ST_WAIT} seq_st_e;

  function automatic logic [ELEM_W-1:0] sext_word(input logic [WORD_W-1:0] w);
    return {{(ELEM_W-WORD_W){w[WORD_W-1]}}, w};
  endfunction
endpackage

// File: rtl/ffl_addr_gen.sv
module ffl_addr_gen #(
  parameter int unsigned AW = 64,
  parameter int unsigned STRIDE = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] index_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned SHIFT = $clog2(STRIDE);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= base_i + (index_i << SHIFT);
    else if (step_i) addr_q <= addr_q + AW'(STRIDE);
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/ffl_vec_buf.sv
module ffl_vec_buf
  import ffl_pkg::*;
#(
  parameter int unsigned N = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [N-1:0]       ffr_in_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [ELEM_W-1:0]  wr_data_i,
  input  logic               wr_ffr_i,
  input  logic               commit_i,
  output logic [N-1:0]       ffr_work_o,
  output logic [N*ELEM_W-1:0] vec_o,
  output logic [N-1:0]       ffr_o
);
  logic [ELEM_W-1:0] res_q [N];
  logic [ELEM_W-1:0] out_q [N];
  logic              fw_q  [N];
  logic              fo_q  [N];

  for (genvar g = 0; g < N; g++) begin : g_elem
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_q[g] <= '0;
        fw_q[g]  <= 1'b0;
      end else if (load_i) begin
        res_q[g] <= '0;
        fw_q[g]  <= ffr_in_i[g];
      end else if (hit) begin
        res_q[g] <= wr_data_i;
        fw_q[g]  <= wr_ffr_i;
      end
    end

    // commit bypasses the element written in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_q[g] <= '0;
        fo_q[g]  <= 1'b0;
      end else if (commit_i) begin
        out_q[g] <= hit ? wr_data_i : res_q[g];
        fo_q[g]  <= hit ? wr_ffr_i  : fw_q[g];
      end
    end

    assign vec_o[g*ELEM_W +: ELEM_W] = out_q[g];
    assign ffr_o[g]      = fo_q[g];
    assign ffr_work_o[g] = fw_q[g];
  end
endmodule

// File: rtl/ffl_ctrl.sv
module ffl_ctrl
  import ffl_pkg::*;
#(
  parameter int unsigned N = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [N-1:0]      pred_i,
  input  logic              base_is_sp_i,
  input  logic [3:0]        base_lo_i,
  input  logic [N-1:0]      ffr_work_i,
  input  logic              mem_req_ready_i,
  input  logic              mem_rsp_valid_i,
  input  logic [WORD_W-1:0] mem_rsp_data_i,
  input  logic              mem_rsp_fault_i,
  output logic              load_o,
  output logic              step_o,
  output logic              mem_req_valid_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [ELEM_W-1:0] wr_data_o,
  output logic              wr_ffr_o,
  output logic              commit_o,
  output logic              done_o,
  output logic              trap_o,
  output logic              align_trap_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N-1);

  seq_st_e          st_q, st_d;
  logic [N-1:0]     pred_q;
  logic             sp_q, misal_q;
  logic [IDX_W-1:0] elem_q;
  logic             first_q, cleared_q;
  logic             done_q, trap_q, algn_q;

  logic fin, fin_trap, fin_algn, cur_ffr, active, is_last, consume;

  assign cur_ffr = ffr_work_i[elem_q];
  assign active  = pred_q[elem_q] && !cleared_q;
  assign is_last = (elem_q == LAST);
  assign consume = (st_q == ST_WAIT) && mem_rsp_valid_i;

  always_comb begin
    st_d            = st_q;
    load_o          = 1'b0;
    step_o          = 1'b0;
    mem_req_valid_o = 1'b0;
    wr_en_o         = 1'b0;
    wr_data_o       = '0;
    wr_ffr_o        = 1'b0;
    fin             = 1'b0;
    fin_trap        = 1'b0;
    fin_algn        = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        load_o = 1'b1;
        st_d   = ST_CHK;
      end
      ST_CHK: begin
        if (sp_q && (|pred_q) && misal_q) begin
          fin = 1'b1; fin_trap = 1'b1; fin_algn = 1'b1;
          st_d = ST_IDLE;
        end else begin
          st_d = ST_STEP;
        end
      end
      ST_STEP: begin
        if (active) begin
          mem_req_valid_o = 1'b1;
          if (mem_req_ready_i) st_d = ST_WAIT;
        end else begin
          wr_en_o  = 1'b1;
          wr_ffr_o = cleared_q ? 1'b0 : cur_ffr;
          step_o   = 1'b1;
          if (is_last) begin fin = 1'b1; st_d = ST_IDLE; end
        end
      end
      ST_WAIT: if (mem_rsp_valid_i) begin
        if (mem_rsp_fault_i && first_q) begin
          fin = 1'b1; fin_trap = 1'b1;
          st_d = ST_IDLE;
        end else begin
          wr_en_o   = 1'b1;
          wr_ffr_o  = mem_rsp_fault_i ? 1'b0 : cur_ffr;
          wr_data_o = (!mem_rsp_fault_i && cur_ffr) ? sext_word(mem_rsp_data_i) : '0;
          step_o    = 1'b1;
          st_d      = is_last ? ST_IDLE : ST_STEP;
          fin       = is_last;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign wr_idx_o = elem_q;
  assign commit_o = fin && !fin_trap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      pred_q    <= '0;
      sp_q      <= 1'b0;
      misal_q   <= 1'b0;
      elem_q    <= '0;
      first_q   <= 1'b0;
      cleared_q <= 1'b0;
      done_q    <= 1'b0;
      trap_q    <= 1'b0;
      algn_q    <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      trap_q <= fin_trap;
      algn_q <= fin_algn;
      if (load_o) begin
        pred_q    <= pred_i;
        sp_q      <= base_is_sp_i;
        misal_q   <= (base_lo_i != 4'd0);
        elem_q    <= '0;
        first_q   <= 1'b1;
        cleared_q <= 1'b0;
      end else begin
        if (step_o && !is_last) elem_q <= elem_q + 1'b1;
        if (consume) first_q <= 1'b0;
        if (consume && mem_rsp_fault_i) cleared_q <= 1'b1;
      end
    end
  end

  assign done_o       = done_q;
  assign trap_o       = trap_q;
  assign align_trap_o = algn_q;

  AST_FIRST_FAULT_TRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume && mem_rsp_fault_i && first_q) |=> (trap_o && done_o)); // R4
  AST_LATE_FAULT_NO_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume && mem_rsp_fault_i && !first_q) |=> !trap_o); // R5
  AST_NO_REQ_AFTER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cleared_q |-> !mem_req_valid_o); // R6
  AST_ALIGN_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_trap_o |-> (trap_o && !mem_req_valid_o)); // R8
endmodule

// File: rtl/ffl_vload_seq.sv
module ffl_vload_seq
  import ffl_pkg::*;
#(
  parameter int unsigned VL_BITS = 512,
  localparam int unsigned N = VL_BITS / ELEM_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [63:0]        base_i,
  input  logic [63:0]        index_i,
  input  logic               base_is_sp_i,
  input  logic [N-1:0]       pred_i,
  input  logic [N-1:0]       ffr_i,
  output logic               mem_req_valid_o,
  input  logic               mem_req_ready_i,
  output logic [63:0]        mem_req_addr_o,
  input  logic               mem_rsp_valid_i,
  input  logic [WORD_W-1:0]  mem_rsp_data_i,
  input  logic               mem_rsp_fault_i,
  output logic [VL_BITS-1:0] vec_o,
  output logic [N-1:0]       ffr_o,
  output logic               done_o,
  output logic               trap_o,
  output logic               align_trap_o
);
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

  logic              load, step, wr_en, wr_ffr, commit;
  logic [IDX_W-1:0]  wr_idx;
  logic [ELEM_W-1:0] wr_data;
  logic [N-1:0]      ffr_work;

  ffl_addr_gen #(.AW(64), .STRIDE(WORD_W/8)) u_addr (
    .clk_i, .rst_ni,
    .load_i (load),
    .base_i, .index_i,
    .step_i (step),
    .addr_o (mem_req_addr_o)
  );

  ffl_ctrl #(.N(N), .IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .pred_i, .base_is_sp_i,
    .base_lo_i      (base_i[3:0]),
    .ffr_work_i     (ffr_work),
    .mem_req_ready_i, .mem_rsp_valid_i, .mem_rsp_data_i, .mem_rsp_fault_i,
    .load_o         (load),
    .step_o         (step),
    .mem_req_valid_o,
    .wr_en_o        (wr_en),
    .wr_idx_o       (wr_idx),
    .wr_data_o      (wr_data),
    .wr_ffr_o       (wr_ffr),
    .commit_o       (commit),
    .done_o, .trap_o, .align_trap_o
  );

  ffl_vec_buf #(.N(N), .IDX_W(IDX_W)) u_buf (
    .clk_i, .rst_ni,
    .load_i     (load),
    .ffr_in_i   (ffr_i),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_data_i  (wr_data),
    .wr_ffr_i   (wr_ffr),
    .commit_i   (commit),
    .ffr_work_o (ffr_work),
    .vec_o, .ffr_o
  );

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> (mem_req_addr_o == $past(mem_req_addr_o) + 64'd4)); // R1
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o))); // R10
  AST_TRAP_KEEPS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> ($stable(vec_o) && $stable(ffr_o) && done_o)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
endmodule

// File: tb/ffl_vload_seq_test.sv
`timescale 1ns/1ps
module ffl_vload_seq_test;
  localparam int VLB = 512;
  localparam int N = VLB / 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, sp = 1'b0;
  logic [63:0] base = '0, idx = '0;
  logic [N-1:0] pred = '0, ffr_in = '0;
  logic req_valid, req_ready = 1'b0;
  logic [63:0] req_addr;
  logic rsp_valid = 1'b0, rsp_fault = 1'b0;
  logic [31:0] rsp_data = '0;
  logic [VLB-1:0] vec;
  logic [N-1:0] ffr;
  logic done, trap, atrap;

  always #2 clk = ~clk;

  ffl_vload_seq #(.VL_BITS(VLB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base), .index_i(idx),
    .base_is_sp_i(sp), .pred_i(pred), .ffr_i(ffr_in),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready), .mem_req_addr_o(req_addr),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data), .mem_rsp_fault_i(rsp_fault),
    .vec_o(vec), .ffr_o(ffr), .done_o(done), .trap_o(trap), .align_trap_o(atrap));

  int n_chk = 0, n_fail = 0;
  logic [63:0] cur_start;
  logic [N-1:0] cur_flt;
  int exp_acc [N];
  int exp_nacc = 0, req_cnt = 0;
  logic [VLB-1:0] st_vec = '0;
  logic [N-1:0] st_ffr = '0;

  task automatic chk(input bit ok, input string req, input logic [VLB-1:0] act, input logic [VLB-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [63:0] a);
    return a[31:0] * 32'h9E3779B1 + 32'h7F4A7C15;
  endfunction

  // memory responder
  initial begin
    bit pend = 0, stalled = 0;
    int wcnt = 0;
    logic [63:0] stall_addr = '0, acc_addr = '0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      rsp_fault = 1'b0;
      if (pend) begin
        if (wcnt == 0) begin
          logic [63:0] off;
          off = (acc_addr - cur_start) >> 2;
          rsp_valid = 1'b1;
          rsp_data  = mem_word(acc_addr);
          rsp_fault = (off < N) ? cur_flt[off[3:0]] : 1'b0;
          pend = 0;
        end else wcnt--;
      end
      if (stalled)
        chk(req_valid && req_addr == stall_addr, "R10 stall hold", VLB'(req_addr), VLB'(stall_addr));
      req_ready = ($urandom % 4) != 0;
      if (req_valid && req_ready) begin
        if (req_cnt < exp_nacc)
          chk(req_addr == cur_start + 64'(4 * exp_acc[req_cnt]), "R1 address",
              VLB'(req_addr), VLB'(cur_start + 64'(4 * exp_acc[req_cnt])));
        else
          chk(1'b0, "R3 R6 unexpected request", VLB'(req_addr), '0);
        req_cnt++;
        acc_addr = req_addr;
        pend = 1;
        wcnt = $urandom % 3;
        stalled = 0;
      end else if (req_valid) begin
        stalled = 1;
        stall_addr = req_addr;
      end else stalled = 0;
    end
  end

  task automatic model(input logic [N-1:0] p, input logic [N-1:0] f, input logic [N-1:0] flt,
                       input logic [63:0] st, input logic [63:0] b, input logic s,
                       output logic [VLB-1:0] v, output logic [N-1:0] fo,
                       output bit tr, output bit al, output int na);
    bit first = 1, clr = 0;
    v = '0; fo = '0; tr = 0; al = 0; na = 0;
    if (s && (|p) && b[3:0] != 4'd0) begin
      tr = 1; al = 1;
    end else begin
      for (int e = 0; e < N; e++) begin
        if (tr) break;
        if (clr) fo[e] = 1'b0;
        else if (!p[e]) fo[e] = f[e];
        else begin
          exp_acc[na] = e; na++;
          if (flt[e] && first) tr = 1;
          else if (flt[e]) begin clr = 1; fo[e] = 1'b0; end
          else begin
            logic [31:0] w;
            w = mem_word(st + 64'(4 * e));
            fo[e] = f[e];
            v[e*64 +: 64] = f[e] ? {{32{w[31]}}, w} : 64'd0;
          end
          first = 0;
        end
      end
    end
    if (tr) begin v = st_vec; fo = st_ffr; end
  endtask

  task automatic run(input logic [N-1:0] p, input logic [N-1:0] f, input logic [N-1:0] flt,
                     input logic [63:0] b, input logic [63:0] ix, input logic s);
    logic [VLB-1:0] ev; logic [N-1:0] ef; bit et, ea; int na; bit seen = 0;
    @(negedge clk);
    cur_start = b + (ix << 2);
    cur_flt = flt;
    req_cnt = 0;
    model(p, f, flt, cur_start, b, s, ev, ef, et, ea, na);
    exp_nacc = na;
    base = b; idx = ix; pred = p; ffr_in = f; sp = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 2000; c++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    if (!seen) begin
      chk(1'b0, "R9 no done (watchdog)", '0, 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
    chk(trap == et, "R4 R8 trap", VLB'(trap), VLB'(et));
    chk(atrap == ea, "R8 align trap", VLB'(atrap), VLB'(ea));
    chk(vec == ev, "R2 R3 R5 R7 vec", vec, ev);
    chk(ffr == ef, "R3 R5 R7 ffr", VLB'(ffr), VLB'(ef));
    chk(req_cnt == na, "R3 R6 request count", VLB'(req_cnt), VLB'(na));
    st_vec = ev; st_ffr = ef;
    @(negedge clk);
    chk(!done && !trap, "R9 done pulse", VLB'({done, trap}), '0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        chk(1'b0, "watchdog", VLB'(cyc), '0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
      end
    end
  end

  localparam logic [N-1:0] ALL = '1;

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(vec == '0 && ffr == '0 && !done && !trap && !atrap && !req_valid, "R11 reset",
        VLB'({done, trap, atrap, req_valid}), '0);
    rst_n = 1'b1;
    // directed corners
    run(ALL, ALL, '0, 64'h1000, 64'd3, 1'b0);              // R1 R2 plain
    run('0, ALL, ALL, 64'h2000, 64'd0, 1'b0);              // R3 all inactive
    run(8'b1111_1100, ALL, 8'b0000_0100, 64'h3000, 0, 0);  // R4 first active behind inactive
    run(ALL, ALL, 8'b1000_0000, 64'h4000, 64'd1, 1'b0);    // R5 fault on last
    run(8'b0101_0111, ALL, 8'b0000_0010, 64'h5000, 0, 0);  // R5 R6 clear then inactive
    run(ALL, 8'b1111_0011, 8'b0100_0000, 64'h6000, 0, 0);  // R7 zero mask bits read
    run(ALL, ALL, '0, 64'h7008, 0, 1'b1);                  // R8 misaligned sp
    run('0, ALL, '0, 64'h7008, 0, 1'b1);                   // R8 no active, no trap
    run(ALL, ALL, '0, 64'h7010, 0, 1'b1);                  // R8 aligned sp
    run(ALL, ALL, '0, 64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF_FFFF_FFFE, 0); // R1 wrap
    for (int t = 0; t < 300; t++) begin
      logic [N-1:0] p, f, fl;
      logic [63:0] b, ix;
      logic s;
      p  = N'($urandom);
      f  = ($urandom % 4 == 0) ? N'($urandom) : ALL;
      fl = '0;
      for (int e = 0; e < N; e++) fl[e] = ($urandom % 6) == 0;
      b  = {$urandom, $urandom};
      b[1:0] = 2'b00;
      ix = ($urandom % 2) ? 64'($urandom % 64) : {$urandom, $urandom};
      s  = ($urandom % 4) == 0;
      if (s && ($urandom % 2)) b[3:0] = 4'd0;
      run(p, f, fl, b, ix, s);
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule